// File: doc/BRIEF.md
# Ethernet PHY Basic Control Register

This block holds the first management register of an Ethernet PHY: the word through which a MAC switches auto-negotiation on or off, restarts it, puts the PHY into low-power mode, and forces the link speed and duplex when negotiation is off. The serial management front end is represented by a single-cycle write strobe with a 16-bit write word, plus a read word that always shows the register's current contents.

Each bit's behaviour depends on the mode. Two board straps can take control away from software. One strap disables auto-negotiation in hardware. The other selects fibre operation, which shuts negotiation off and lets a duplex pin drive the duplex bit. The negotiation engine supplies the negotiated duplex and a done flag. The register returns a one-cycle restart pulse, a power-down level and the forced speed and duplex levels to that engine.

Top module: `phy_ctrl_reg`

## Requirements
- R1: After reset, with the hardware enable strap high and fibre mode off, the read word is 0x1000 (bit 12 set, all others 0), `anEnable` is 1, and `anRestart`, `powerDown`, `forceSpeed100` and `forceFullDuplex` are 0.
- R2: With the hardware enable strap high and fibre mode off, a write stores bit 12. Bit 12 reads back the last value written, or 1 if it has not been written since reset. `anEnable` follows the stored value.
- R3: While the hardware enable strap `hwAnEnable` is low, `anEnable` is 0 and writes do not change the stored bit 12.
- R4: While `fiberMode` is high, bit 12 reads 0, `anEnable` is 0, and writes do not change the stored bit 12.
- R5: While `anEnable` is 0, `forceSpeed100` equals the stored bit 13 and `forceFullDuplex` equals the stored bit 8. While `anEnable` is 1, both outputs are 0. Bit 13 is always writable and reads back what was stored.
- R6: Bit 8 resets to 0 (half duplex). While `anEnable` is 1, writes to bit 8 are ignored and bit 8 reads `anDone & anDuplex`. While `anEnable` is 0, bit 8 is read/write.
- R7: A write with bit 9 set while `anEnable` is 1 produces `anRestart` high for exactly the next cycle. Each such write makes its own pulse. A write with bit 9 set while `anEnable` is 0 makes no pulse. Bit 9 always reads 0.
- R8: Bit 11 is power-down and is writable in every mode, including while powered down. `powerDown` and read bit 11 equal the last value written, which is 0 after reset.
- R9: Bits 15, 14, 10 and 7:0 always read 0, and writes to them have no effect.
- R10: In fibre mode, bit 8 takes the level of `fiberDuplexPin` at the clock edge after that pin differs from its previous sampled value (the sample is 0 after reset). If a write lands on that same edge, the written bit 8 wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| wrData | input | 16 | Write word |
| rdData | output | 16 | Current read view of the register |
| hwAnEnable | input | 1 | Hardware strap; low disables auto-negotiation |
| fiberMode | input | 1 | Fibre (100 Mb/s optical) mode strap |
| fiberDuplexPin | input | 1 | Fibre duplex pin, 1 = full duplex |
| anDuplex | input | 1 | Duplex result from the negotiation engine |
| anDone | input | 1 | Negotiation complete flag |
| anEnable | output | 1 | Effective auto-negotiation enable |
| anRestart | output | 1 | One-cycle restart pulse to the negotiation engine |
| powerDown | output | 1 | Low-power request |
| forceSpeed100 | output | 1 | Forced 100 Mb/s when negotiation is off |
| forceFullDuplex | output | 1 | Forced full duplex when negotiation is off |

## Verification
Two updates can land on one clock edge: a management write of bit 8 and a fibre duplex pin toggle. The bench provokes this by flipping the pin in the same cycle as a write that carries the opposite duplex value. It then checks that bit 8 shows the written value on the next cycle rather than the pin level. A second collision comes from a single write that both clears bit 12 and sets bit 9. The bench expects the restart pulse to follow the enable state from before that write, so the pulse still appears. A behavioural model predicts every output field on every cycle, and both collisions are also repeated under random stimulus.

// File: rtl/phy_ctrl_pkg.sv
package phy_ctrl_pkg;
  localparam int REG_W      = 16;
  localparam int BIT_SPEED  = 13;
  localparam int BIT_ANEN   = 12;
  localparam int BIT_PDOWN  = 11;
  localparam int BIT_RSTRT  = 9;
  localparam int BIT_DUPLEX = 8;

  typedef struct packed {
    logic ldAnEn;
    logic ldSpeed;
    logic ldDuplex;
    logic ldPower;
    logic ldPinDuplex;
    logic restart;
  } ctrlStrobes_t;
endpackage

// File: rtl/phy_ctrl_ctl.sv
module phy_ctrl_ctl
  import phy_ctrl_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [W-1:0]         wrData,
  input  logic                 hwAnEnable,
  input  logic                 fiberMode,
  input  logic                 fiberDuplexPin,
  input  logic                 anEnableEff,
  output ctrlStrobes_t         strobes,
  output logic                 anRestart
);
  logic pinPrev;
  logic pinToggled;
  logic softAnAllowed;

  assign softAnAllowed = hwAnEnable & ~fiberMode;
  assign pinToggled    = fiberMode & (fiberDuplexPin != pinPrev);

  always_comb begin
    strobes             = '0;
    strobes.ldAnEn      = wrEn & softAnAllowed;
    strobes.ldSpeed     = wrEn;
    strobes.ldPower     = wrEn;
    strobes.ldDuplex    = wrEn & ~anEnableEff;
    strobes.ldPinDuplex = pinToggled & ~strobes.ldDuplex;
    strobes.restart     = wrEn & wrData[BIT_RSTRT] & anEnableEff;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinPrev   <= 1'b0;
      anRestart <= 1'b0;
    end else begin
      pinPrev   <= fiberDuplexPin;
      anRestart <= strobes.restart;
    end
  end
endmodule

// File: rtl/phy_ctrl_dp.sv
module phy_ctrl_dp
  import phy_ctrl_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic [W-1:0]         wrData,
  input  logic                 hwAnEnable,
  input  logic                 fiberMode,
  input  logic                 fiberDuplexPin,
  input  logic                 anDuplex,
  input  logic                 anDone,
  output logic                 anEnableEff,
  output logic [W-1:0]         rdData,
  output logic                 powerDown,
  output logic                 forceSpeed100,
  output logic                 forceFullDuplex
);
  logic anEnReg;
  logic speedReg;
  logic duplexReg;
  logic powerReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      anEnReg   <= 1'b1;
      speedReg  <= 1'b0;
      duplexReg <= 1'b0;
      powerReg  <= 1'b0;
    end else begin
      if (strobes.ldAnEn)      anEnReg   <= wrData[BIT_ANEN];
      if (strobes.ldSpeed)     speedReg  <= wrData[BIT_SPEED];
      if (strobes.ldPower)     powerReg  <= wrData[BIT_PDOWN];
      if (strobes.ldDuplex)    duplexReg <= wrData[BIT_DUPLEX];
      else if (strobes.ldPinDuplex) duplexReg <= fiberDuplexPin;
    end
  end

  assign anEnableEff     = anEnReg & hwAnEnable & ~fiberMode;
  assign powerDown       = powerReg;
  assign forceSpeed100   = ~anEnableEff & speedReg;
  assign forceFullDuplex = ~anEnableEff & duplexReg;

  always_comb begin
    rdData             = '0;
    rdData[BIT_SPEED]  = speedReg;
    rdData[BIT_ANEN]   = fiberMode ? 1'b0 : anEnReg;
    rdData[BIT_PDOWN]  = powerReg;
    rdData[BIT_DUPLEX] = anEnableEff ? (anDone & anDuplex) : duplexReg;
  end
endmodule

// File: rtl/phy_ctrl_reg.sv
module phy_ctrl_reg
  import phy_ctrl_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] rdData,
  input  logic         hwAnEnable,
  input  logic         fiberMode,
  input  logic         fiberDuplexPin,
  input  logic         anDuplex,
  input  logic         anDone,
  output logic         anEnable,
  output logic         anRestart,
  output logic         powerDown,
  output logic         forceSpeed100,
  output logic         forceFullDuplex
);
  ctrlStrobes_t strobes;
  logic         anEnableEff;

  phy_ctrl_ctl #(.W(W)) ctl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .hwAnEnable(hwAnEnable), .fiberMode(fiberMode),
    .fiberDuplexPin(fiberDuplexPin), .anEnableEff(anEnableEff),
    .strobes(strobes), .anRestart(anRestart)
  );

  phy_ctrl_dp #(.W(W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .hwAnEnable(hwAnEnable), .fiberMode(fiberMode),
    .fiberDuplexPin(fiberDuplexPin), .anDuplex(anDuplex), .anDone(anDone),
    .anEnableEff(anEnableEff), .rdData(rdData), .powerDown(powerDown),
    .forceSpeed100(forceSpeed100), .forceFullDuplex(forceFullDuplex)
  );

  assign anEnable = anEnableEff;
endmodule

// File: rtl/phy_ctrl_chk.sv
module phy_ctrl_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         wrEn,
  input logic [W-1:0] wrData,
  input logic [W-1:0] rdData,
  input logic         hwAnEnable,
  input logic         fiberMode,
  input logic         anEnable,
  input logic         anRestart,
  input logic         powerDown,
  input logic         forceSpeed100,
  input logic         forceFullDuplex
);
  assert_hw_disable_R3: assert property (@(posedge clk) disable iff (!rstN)
    !hwAnEnable |-> !anEnable);

  assert_fiber_reads_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    fiberMode |-> (!rdData[12] && !anEnable));

  assert_forced_gated_R5: assert property (@(posedge clk) disable iff (!rstN)
    anEnable |-> (!forceSpeed100 && !forceFullDuplex));

  assert_restart_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    anRestart |-> $past(wrEn && wrData[9] && anEnable));

  assert_restart_reads_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    !rdData[9]);

  assert_power_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (powerDown == $past(wrData[11])));

  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[15:14] == 2'b00) && !rdData[10] && (rdData[7:0] == 8'h00));
endmodule

bind phy_ctrl_reg phy_ctrl_chk #(.W(W)) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
  .hwAnEnable(hwAnEnable), .fiberMode(fiberMode), .anEnable(anEnable),
  .anRestart(anRestart), .powerDown(powerDown),
  .forceSpeed100(forceSpeed100), .forceFullDuplex(forceFullDuplex)
);

// File: tb/phy_ctrl_reg_tb.sv
module phy_ctrl_reg_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [15:0] wrData;
  logic [15:0] rdData;
  logic        hwAnEnable, fiberMode, fiberDuplexPin, anDuplex, anDone;
  logic        anEnable, anRestart, powerDown, forceSpeed100, forceFullDuplex;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  // reference state
  bit mAnEn, mSpeed, mDup, mPd, mPin, mRst;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_ctrl_reg dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .hwAnEnable(hwAnEnable), .fiberMode(fiberMode),
    .fiberDuplexPin(fiberDuplexPin), .anDuplex(anDuplex), .anDone(anDone),
    .anEnable(anEnable), .anRestart(anRestart), .powerDown(powerDown),
    .forceSpeed100(forceSpeed100), .forceFullDuplex(forceFullDuplex)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    if (act != exp) begin
      misses++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic modelReset();
    mAnEn = 1; mSpeed = 0; mDup = 0; mPd = 0; mPin = 0; mRst = 0;
  endtask

  // one clock: drive, compare against model, advance model
  task automatic cycle(input bit we, input bit [15:0] wd, input bit hw,
                       input bit fib, input bit pin, input bit dn, input bit dp);
    bit eff;
    bit [15:0] exp;
    bit nAnEn, nSpeed, nDup, nPd, nRst;
    string t12, t8;
    @(negedge clk);
    wrEn = we; wrData = wd; hwAnEnable = hw; fiberMode = fib;
    fiberDuplexPin = pin; anDone = dn; anDuplex = dp;
    #1;
    vectors++;
    eff = mAnEn && hw && !fib;
    exp = 16'h0000;
    exp[13] = mSpeed;
    exp[12] = fib ? 1'b0 : mAnEn;
    exp[11] = mPd;
    exp[8]  = eff ? (dn && dp) : mDup;
    t12 = fib ? "R4" : (hw ? "R2" : "R3");
    t8  = fib ? "R10" : "R6";
    chk(t12,  "rd bit12",   int'(rdData[12]), int'(exp[12]));
    chk("R5", "rd bit13",   int'(rdData[13]), int'(exp[13]));
    chk(t8,   "rd bit8",    int'(rdData[8]),  int'(exp[8]));
    chk("R7", "rd bit9",    int'(rdData[9]),  0);
    chk("R8", "rd bit11",   int'(rdData[11]), int'(exp[11]));
    chk("R9", "rd reserved", int'(rdData & 16'hC4FF), 0);
    chk(t12,  "anEnable",   int'(anEnable), int'(eff));
    chk("R5", "forceSpeed100",   int'(forceSpeed100),   int'(!eff && mSpeed));
    chk("R5", "forceFullDuplex", int'(forceFullDuplex), int'(!eff && mDup));
    chk("R8", "powerDown",  int'(powerDown), int'(mPd));
    chk("R7", "anRestart",  int'(anRestart), int'(mRst));
    nAnEn = mAnEn; nSpeed = mSpeed; nDup = mDup; nPd = mPd;
    nRst = we && wd[9] && eff;
    if (we) begin
      if (hw && !fib) nAnEn = wd[12];
      nSpeed = wd[13];
      nPd = wd[11];
      if (!eff) nDup = wd[8];
    end
    if (fib && (pin != mPin) && !(we && !eff)) nDup = pin;
    @(posedge clk);
    mAnEn = nAnEn; mSpeed = nSpeed; mDup = nDup; mPd = nPd; mRst = nRst; mPin = pin;
  endtask

  task automatic idle(input bit hw, input bit fib, input bit pin);
    cycle(0, 16'h0, hw, fib, pin, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    rstN = 0; wrEn = 0; wrData = 0; hwAnEnable = 1; fiberMode = 0;
    fiberDuplexPin = 0; anDuplex = 0; anDone = 0;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    #1;
    // R1: reset state
    vectors++;
    chk("R1", "reset rdData", int'(rdData), 16'h1000);
    chk("R1", "reset anEnable", int'(anEnable), 1);
    chk("R1", "reset outputs",
        int'({anRestart, powerDown, forceSpeed100, forceFullDuplex}), 0);

    // R6: negotiated duplex visible, duplex write ignored while enabled
    cycle(1, 16'h1100, 1, 0, 0, 1, 1);
    cycle(0, 16'h0, 1, 0, 0, 1, 0);
    // R7: restart pulses, back to back
    cycle(1, 16'h1200, 1, 0, 0, 0, 0);
    cycle(1, 16'h1200, 1, 0, 0, 0, 0);
    idle(1, 0, 0); idle(1, 0, 0);
    // R7: restart written together with bit12 cleared still pulses
    cycle(1, 16'h0200, 1, 0, 0, 0, 0);
    idle(1, 0, 0);
    // R7: restart while disabled does nothing
    cycle(1, 16'h0200, 1, 0, 0, 0, 0);
    idle(1, 0, 0);
    // R5: forced speed and duplex while disabled
    cycle(1, 16'h2100, 1, 0, 0, 0, 0);
    idle(1, 0, 0);
    // R2: re-enable by write
    cycle(1, 16'h3100, 1, 0, 0, 0, 0);
    idle(1, 0, 0);
    // R3: hardware disable, bit12 writes ignored
    idle(0, 0, 0);
    cycle(1, 16'h0000, 0, 0, 0, 0, 0);
    cycle(1, 16'h1000, 0, 0, 0, 0, 0);
    idle(1, 0, 0);
    // R8: power-down and access while powered down
    cycle(1, 16'h1800, 1, 0, 0, 0, 0);
    cycle(1, 16'h0800, 1, 0, 0, 0, 0);
    cycle(1, 16'h1000, 1, 0, 0, 0, 0);
    // R9: reserved bits written as ones
    cycle(1, 16'hD4FF, 1, 0, 0, 0, 0);
    idle(1, 0, 0);
    // R4: fibre mode
    idle(1, 1, 0);
    cycle(1, 16'h1000, 1, 1, 0, 0, 0);
    // R10: pin toggles
    idle(1, 1, 1); idle(1, 1, 1); idle(1, 1, 0); idle(1, 1, 0);
    // R10: pin toggle collides with write of opposite value
    cycle(1, 16'h0000, 1, 1, 1, 0, 0);
    idle(1, 1, 1);
    cycle(1, 16'h0100, 1, 1, 0, 0, 0);
    idle(1, 1, 0);
    idle(1, 0, 0); idle(1, 0, 0);

    // random stimulus
    for (int i = 0; i < 4000; i++) begin
      bit [15:0] w;
      w = 16'($urandom);
      cycle(($urandom % 3) == 0, w, ($urandom % 5) != 0, ($urandom % 4) == 0,
            ($urandom % 3) == 0 ? ~mPin : mPin, 1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule